// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block models a small synchronous SRAM with a four-word burst. Address and controls are captured on the rising clock edge. Read data comes straight out of the array from the captured address, with no output register, so a word appears in the same cycle that its address was loaded. A two-bit counter walks the four words of the aligned group that holds the starting address, in linear or interleaved order. Either of two address strobes can open a burst. An advance input steps through the burst. Writes are controlled per byte lane, and a global write covers every lane. Three chip selects are sampled at the clock edge. An output enable controls the shared bidirectional data bus directly, without waiting for a clock.

The data bus is a plain shared SRAM bus, not a stream, so it has no valid/ready handshake. In any cycle the bus either carries read data or is released. A host that writes drives the bus itself while it asserts the write controls. Write controls in a cycle act on the word the block presents in that cycle, and the data is stored at the closing clock edge. All controls are active low except `ce_b`, which is active high. Byte lane i is data bits [8i+7:8i].

Top module: `sram_burst_top`

## Requirements
- R1: With `mode_ilv` low, beat k of a burst (k = 0..3) addresses word offset (start + k) mod 4 in the group.
- R2: With `mode_ilv` high, beat k addresses word offset start XOR k.
- R3: When `ctrl_stb_n` is low at a clock edge, a new burst starts at `addr`, whatever the other strobe and chip selects are.
- R4: When `proc_stb_n` is low at a clock edge while `ce_a_n` is high, it has no effect. When `proc_stb_n` is low with `ce_a_n` low, a new burst starts at `addr`.
- R5: When no burst starts, `adv_n` low moves to the next beat, and `adv_n` high keeps the current word.
- R6: With `glob_wr_n` high, a write stores only the lanes whose `lane_wr_n` bit is low. The other lanes keep their contents.
- R7: With `glob_wr_n` low, all lanes are written, whatever the value of `lane_wr_n`.
- R8: A burst start selects the block only if `ce_a_n` is low, `ce_b` is high and `ce_c_n` is low. A deselected block releases the bus and ignores writes.
- R9: `oe_n` high releases the bus at once, with no clock edge needed.
- R10: The block releases the bus in any cycle in which a write control is asserted.
- R11: Read data for a newly loaded address is on the bus in the same cycle, with no added latency.
- R12: After reset the block is deselected and the bus is released.
- R13: The address bits above the two low bits do not change during a burst, including when the burst wraps after the fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address captured on a burst start |
| proc_stb_n | input | 1 | Processor-side burst strobe, active low, gated by `ce_a_n` |
| ctrl_stb_n | input | 1 | Controller-side burst strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| data | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench builds the block with its default parameters: 64 words of four 8-bit lanes, which makes 16 burst groups. Each group is filled with a distinct arithmetic pattern. Every combination of order mode, starting offset and start strobe then gets a group of its own, so all 16 burst sequences, and the wrap back to the first beat, are compared against a reference array in the bench. Cases in which the bus must be released are accepted as either high impedance or an undriven zero, which can never be a stored word.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  // Offset of beat 'step' within a four-word group
  function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                             input logic [1:0] step,
                                             input logic       interleave);
    return interleave ? (first ^ step) : (first + step);
  endfunction
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              ce_a_n,
  input  logic              sel,
  input  logic              adv_n,
  input  logic              mode_ilv,
  output logic              active,
  output logic [1:0]        burst_cnt,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic              go;
  logic [ADDR_W-1:0] base_q;

  assign go = !ctrl_stb_n || (!proc_stb_n && !ce_a_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      base_q    <= '0;
      burst_cnt <= '0;
    end else if (go) begin
      active    <= sel;
      base_q    <= addr;
      burst_cnt <= '0;
    end else if (!adv_n) begin
      burst_cnt <= burst_cnt + 2'd1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                     beat_offset(base_q[1:0], burst_cnt, mode_ilv)};
endmodule

// File: rtl/sram_burst_array.sv
module sram_burst_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    adv_n,
  input  logic                    mode_ilv,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    oe_n,
  input  logic                    glob_wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  inout  wire  [LANES*LANE_W-1:0] data
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel;
  logic              active;
  logic [1:0]        burst_cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic              writing;
  logic [LANES-1:0]  lane_sel;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rd_word;
  logic              drv_en;

  assign sel = !ce_a_n && ce_b && !ce_c_n;

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce_a_n     (ce_a_n),
    .sel        (sel),
    .adv_n      (adv_n),
    .mode_ilv   (mode_ilv),
    .active     (active),
    .burst_cnt  (burst_cnt),
    .cur_addr   (cur_addr)
  );

  // Global write overrides the per-lane selects
  assign writing  = !glob_wr_n || !(&lane_wr_n);
  assign lane_sel = glob_wr_n ? ~lane_wr_n : {LANES{1'b1}};
  assign lane_we  = active ? lane_sel : '0;

  sram_burst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .lane_we (lane_we),
    .addr    (cur_addr),
    .wdata   (data),
    .rdata   (rd_word)
  );

  // Flow-through read: array output goes to the bus without a register
  assign drv_en = active && !oe_n && !writing;
  assign data   = drv_en ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              mode_ilv,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              oe_n,
  input logic              glob_wr_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              active,
  input logic [1:0]        burst_cnt,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              drv_en
);
  logic no_go;
  assign no_go = ctrl_stb_n && (proc_stb_n || ce_a_n);

  AST_CTRL_START: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_stb_n |=> (burst_cnt == 2'd0) && (active == $past(!ce_a_n && ce_b && !ce_c_n))); // R3
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && ce_a_n && ctrl_stb_n && adv_n) |=> $stable(active) && $stable(burst_cnt)); // R4
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_go && !adv_n) |=> burst_cnt == $past(burst_cnt) + 2'd1); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_go && adv_n) |=> $stable(burst_cnt)); // R5
  AST_LINEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (no_go && !adv_n && !mode_ilv) |=> (mode_ilv || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R1
  AST_ILV_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (no_go && mode_ilv) |=> (!mode_ilv || (cur_addr[1:0] ^ burst_cnt) == $past(cur_addr[1:0] ^ burst_cnt))); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    no_go |=> $stable(cur_addr[ADDR_W-1:2])); // R13
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !drv_en); // R8
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drv_en); // R9
  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_wr_n || !(&lane_wr_n)) |-> !drv_en); // R10
endmodule

bind sram_burst_top sram_burst_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .adv_n      (adv_n),
  .mode_ilv   (mode_ilv),
  .ce_a_n     (ce_a_n),
  .ce_b       (ce_b),
  .ce_c_n     (ce_c_n),
  .oe_n       (oe_n),
  .glob_wr_n  (glob_wr_n),
  .lane_wr_n  (lane_wr_n),
  .active     (active),
  .burst_cnt  (burst_cnt),
  .cur_addr   (cur_addr),
  .drv_en     (drv_en)
);

// File: tb/sram_burst_top_test.sv
module sram_burst_top_test;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_stb_n, ctrl_stb_n, adv_n, mode_ilv;
  logic          ce_a_n, ce_b, ce_c_n, oe_n, glob_wr_n;
  logic [NL-1:0] lane_wr_n;
  logic          tb_drv;
  logic [DW-1:0] tb_val;
  wire  [DW-1:0] data;

  logic [DW-1:0] ref_mem [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign data = tb_drv ? tb_val : {DW{1'bz}};

  always #5 clk = ~clk;

  sram_burst_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .mode_ilv(mode_ilv),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .oe_n(oe_n),
    .glob_wr_n(glob_wr_n), .lane_wr_n(lane_wr_n), .data(data)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hA5, b + 8'h11, ~b, b | 8'h40};
  endfunction

  function automatic int offs(input int s, input int k, input int ilv);
    return ilv != 0 ? (s ^ k) : ((s + k) % 4);
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
    ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    glob_wr_n = 1; lane_wr_n = '1; tb_drv = 0;
  endtask

  task automatic start_burst(input int a, input bit use_ctrl);
    addr = AW'(a);
    if (use_ctrl) ctrl_stb_n = 0; else proc_stb_n = 0;
    cyc();
    ctrl_stb_n = 1; proc_stb_n = 1;
  endtask

  task automatic check_word(input string req, input logic [DW-1:0] exp);
    #1;
    checks++;
    if (data !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, data, exp);
    end
  endtask

  task automatic check_rel(input string req);
    #1;
    checks++;
    if (!(data === {DW{1'bz}} || data === {DW{1'b0}})) begin
      errors++;
      $display("FAIL %s: got %h expected released bus", req, data);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    addr = '0; mode_ilv = 0; oe_n = 0; tb_val = '0; rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    check_rel("R12 reset");

    // Fill every group with global writes, linear from offset 0
    for (int g = 0; g < 16; g++) begin
      start_burst(g * 4, g[0]);
      for (int k = 0; k < 4; k++) begin
        tb_drv = 1; tb_val = pat(g * 4 + k); glob_wr_n = 0; adv_n = 0;
        ref_mem[g * 4 + k] = pat(g * 4 + k);
        cyc();
      end
      idle();
    end

    // Sweep: mode x start offset x strobe, one group each (R1, R2, R11, R13)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int st = 0; st < 2; st++) begin
          int g;
          g = m * 8 + s * 2 + st;
          mode_ilv = m[0];
          start_burst(g * 4 + s, st[0]);
          for (int k = 0; k < 4; k++) begin
            check_word(m != 0 ? "R2 interleaved beat (R11)" : "R1 linear beat (R11)",
                       ref_mem[g * 4 + offs(s, k, m)]);
            adv_n = 0; cyc(); adv_n = 1;
          end
          check_word("R13 wrap stays in group", ref_mem[g * 4 + s]);
        end
      end
    end
    mode_ilv = 0;

    // R5 hold with adv_n high
    start_burst(8, 1'b1);
    cyc(); cyc();
    check_word("R5 hold", ref_mem[8]);

    // R4 processor strobe ignored while ce_a_n high
    proc_stb_n = 0; ce_a_n = 1; addr = 6'd40;
    cyc();
    idle();
    check_word("R4 gated strobe ignored", ref_mem[8]);
    start_burst(40, 1'b0);
    check_word("R4 processor strobe start", ref_mem[40]);

    // R3/R8 controller strobe while deselected
    ce_a_n = 1;
    start_burst(12, 1'b1);
    ce_a_n = 0;
    check_rel("R3 ctrl strobe deselects");
    tb_drv = 1; tb_val = 32'hDEADBEEF; glob_wr_n = 0;
    cyc();
    idle();
    start_burst(12, 1'b1);
    check_word("R8 write ignored when deselected", ref_mem[12]);
    ce_b = 0;
    start_burst(13, 1'b1);
    ce_b = 1;
    check_rel("R8 ce_b low deselects");
    ce_c_n = 1;
    start_burst(14, 1'b1);
    ce_c_n = 0;
    check_rel("R8 ce_c_n high deselects");

    // R6 byte lane write, R10 release during write
    start_burst(20, 1'b1);
    lane_wr_n = 4'b1010;
    check_rel("R10 released in write cycle");
    tb_drv = 1; tb_val = 32'h11223344;
    cyc();
    idle();
    ref_mem[20] = {ref_mem[20][31:24], 8'h22, ref_mem[20][15:8], 8'h44};
    check_word("R6 lane write", ref_mem[20]);

    // R7 global overrides lane selects
    glob_wr_n = 0; lane_wr_n = 4'b1110; tb_drv = 1; tb_val = 32'hCAFEF00D;
    cyc();
    idle();
    ref_mem[20] = 32'hCAFEF00D;
    check_word("R7 global write", ref_mem[20]);

    // R9 output enable without clock
    oe_n = 1;
    check_rel("R9 oe high releases");
    oe_n = 0;
    check_word("R9 oe low drives", ref_mem[20]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule